// File: doc/BRIEF.md
# Frame-Synchronous Control Register Bank

This block holds the host-programmable settings of a video scaling engine. A host reaches it through a 32-bit word-addressed slave port with per-byte write enables, and may read or write at any moment. The settings are a run flag, two edge-adaptive feature enables, the output frame dimensions and an edge threshold.

The engine never sees the host registers directly. When the pipeline pulses `frame_start`, the block copies every setting into a shadow set. The shadow set drives the engine for the whole frame, so a write made mid-frame waits for the next frame boundary. When a capture finds the run flag clear, the engine's run output falls and stays low until a later capture finds the flag set again. The threshold passed to the engine is the programmed value multiplied by the compile-time number of colour planes.

Top module: `frame_ctrl_regs`

## Requirements
- R1: A write changes only the byte lanes whose `host_be` bit is set (lane i is `host_wdata[8i+7:8i]`). Bits above a register's implemented width are dropped on write and read as 0.
- R2: Word addresses are decoded as follows. Address 0 is control: bit 0 is run, bit 1 is edge-coefficient enable, bit 2 is edge-sharpen enable, and the other bits read 0. Address 3 is output width (16 bits). Address 4 is output height (16 bits). Address 5 is the edge threshold (16 bits). Reads of these addresses return the host-written values, not the shadow copies.
- R3: Read data appears on `host_rdata` in the cycle after the cycle in which `host_rd` is high. In any cycle that follows one without a read, `host_rdata` is 0.
- R4: The engine-side outputs change only in the cycle after a `frame_start` pulse. They then take the host register values from before any write made in that same cycle.
- R5: Clearing the run bit leaves `run` high until the next `frame_start`. At that capture `run` drops to 0.
- R6: Address 1 is status. Bit 0 equals the current `run` output, which is 0 until the engine has first been started. All other status bits read 0.
- R7: Address 2 reads 0, and writes to it change nothing.
- R8: After a capture, `edge_thresh` equals the captured threshold register times `PLANES` (3 by default).
- R9: Addresses 6 and 7 read 0, and writes to them change no register or output.
- R10: After reset, every register, shadow copy and output is 0, so `run` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Word address |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_be | input | 4 | Byte-lane enables for writes |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, one cycle after `host_rd` |
| frame_start | input | 1 | Single-cycle capture pulse from the pipeline |
| run | output | 1 | Captured run flag |
| edge_coef_en | output | 1 | Captured edge-adaptive coefficient enable |
| edge_sharp_en | output | 1 | Captured edge-adaptive sharpening enable |
| out_width | output | 16 | Captured output width in pixels |
| out_height | output | 16 | Captured output height in pixels |
| edge_thresh | output | 18 | Captured threshold times the plane count |

## Verification
The checker assumes `frame_start` is a single-cycle pulse. It also assumes `host_rd` and `host_wr` may be high together, in which case the read returns the value from before the write. The bench drives each strobe for exactly one cycle, launched on the falling edge. Every `frame_start` pulse is separated by at least one idle cycle. Only one case deliberately lines a write up with a capture, so that the capture takes the pre-write value.

// File: rtl/frame_ctrl_regs.sv
module frame_ctrl_regs #(
  parameter int ADDR_W = 3,
  parameter int DIM_W  = 16,
  parameter int THR_W  = 16,
  parameter int PLANES = 3,
  localparam int THR_OUT_W = THR_W + $clog2(PLANES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic [3:0]           host_be,
  input  logic [31:0]          host_wdata,
  output logic [31:0]          host_rdata,
  input  logic                 frame_start,
  output logic                 run,
  output logic                 edge_coef_en,
  output logic                 edge_sharp_en,
  output logic [DIM_W-1:0]     out_width,
  output logic [DIM_W-1:0]     out_height,
  output logic [THR_OUT_W-1:0] edge_thresh
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_WID  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_HGT  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(5);
  localparam logic [THR_OUT_W-1:0] PLANES_V = THR_OUT_W'(PLANES);

  logic [2:0]       ctrl_q;
  logic [DIM_W-1:0] width_q, height_q;
  logic [THR_W-1:0] thr_q;
  logic [31:0]      rd_mux, merged;

  function automatic logic [31:0] lane_merge(input logic [31:0] old,
                                             input logic [31:0] nw,
                                             input logic [3:0]  be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++)
      r[8*i +: 8] = be[i] ? nw[8*i +: 8] : old[8*i +: 8];
    return r;
  endfunction

  always_comb begin
    case (host_addr)
      A_CTRL:  rd_mux = 32'(ctrl_q);
      A_STAT:  rd_mux = 32'(run);
      A_WID:   rd_mux = 32'(width_q);
      A_HGT:   rd_mux = 32'(height_q);
      A_THR:   rd_mux = 32'(thr_q);
      default: rd_mux = '0;
    endcase
  end

  assign merged = lane_merge(rd_mux, host_wdata, host_be);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      width_q  <= '0;
      height_q <= '0;
      thr_q    <= '0;
    end else if (host_wr) begin
      case (host_addr)
        A_CTRL:  ctrl_q   <= merged[2:0];
        A_WID:   width_q  <= merged[DIM_W-1:0];
        A_HGT:   height_q <= merged[DIM_W-1:0];
        A_THR:   thr_q    <= merged[THR_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) host_rdata <= '0;
    else        host_rdata <= host_rd ? rd_mux : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run           <= 1'b0;
      edge_coef_en  <= 1'b0;
      edge_sharp_en <= 1'b0;
      out_width     <= '0;
      out_height    <= '0;
      edge_thresh   <= '0;
    end else if (frame_start) begin
      run           <= ctrl_q[0];
      edge_coef_en  <= ctrl_q[1];
      edge_sharp_en <= ctrl_q[2];
      out_width     <= width_q;
      out_height    <= height_q;
      edge_thresh   <= THR_OUT_W'(thr_q) * PLANES_V;
    end
  end
endmodule

module frame_ctrl_regs_chk #(
  parameter int ADDR_W = 3,
  parameter int DIM_W  = 16,
  parameter int THR_W  = 16,
  parameter int PLANES = 3,
  parameter int THR_OUT_W = THR_W + $clog2(PLANES + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    host_addr,
  input logic                 host_rd,
  input logic [31:0]          host_rdata,
  input logic                 frame_start,
  input logic                 run,
  input logic                 edge_coef_en,
  input logic                 edge_sharp_en,
  input logic [DIM_W-1:0]     out_width,
  input logic [DIM_W-1:0]     out_height,
  input logic [THR_OUT_W-1:0] edge_thresh,
  input logic [DIM_W-1:0]     width_q,
  input logic [THR_W-1:0]     thr_q
);
  localparam logic [THR_OUT_W-1:0] PV = THR_OUT_W'(PLANES);

  // R3
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> host_rdata == '0);
  // R6
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == ADDR_W'(1)) |=> host_rdata == 32'($past(run)));
  // R7
  intr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == ADDR_W'(2)) |=> host_rdata == '0);
  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr > ADDR_W'(5)) |=> host_rdata == '0);
  // R4
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(out_width) && $stable(out_height) && $stable(edge_thresh)
                     && $stable(edge_coef_en) && $stable(edge_sharp_en));
  // R4
  width_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> out_width == $past(width_q));
  // R5
  run_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> $past(frame_start));
  // R8
  thresh_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> edge_thresh == THR_OUT_W'($past(thr_q)) * PV);
endmodule

bind frame_ctrl_regs frame_ctrl_regs_chk #(
  .ADDR_W(ADDR_W), .DIM_W(DIM_W), .THR_W(THR_W), .PLANES(PLANES), .THR_OUT_W(THR_OUT_W)
) chk_i (.*);

// File: tb/frame_ctrl_regs_test.sv
module frame_ctrl_regs_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [3:0]  host_be = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        frame_start = 1'b0;
  logic        run, edge_coef_en, edge_sharp_en;
  logic [15:0] out_width, out_height;
  logic [17:0] edge_thresh;

  int checks = 0, fails = 0;

  frame_ctrl_regs uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d, logic [3:0] be, logic fs = 1'b0);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_be = be; host_wr = 1'b1; frame_start = fs;
    @(negedge clk);
    host_wr = 1'b0; frame_start = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R10 run", 32'(run), 0);
    check("R10 width", 32'(out_width), 0);
    check("R10 thresh", 32'(edge_thresh), 0);
    rd(3'd0, d); check("R10 ctrl", d, 0);
    rd(3'd1, d); check("R6 status before start", d, 0);
  endtask

  task automatic t_lanes();
    logic [31:0] d;
    wr(3'd3, 32'h0000_1234, 4'b1111);
    wr(3'd3, 32'hFFFF_AB00, 4'b0010);
    rd(3'd3, d); check("R1 single lane", d, 32'h0000_AB34);
    wr(3'd3, 32'hFFFF_0000, 4'b1100);
    rd(3'd3, d); check("R1 upper lanes dropped", d, 32'h0000_AB34);
    wr(3'd5, 32'h0000_00CD, 4'b0001);
    rd(3'd5, d); check("R1 thr low lane", d, 32'h0000_00CD);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(3'd0, 32'hFFFF_FFFF, 4'b1111);
    rd(3'd0, d); check("R2 ctrl bits", d, 32'h7);
    wr(3'd4, 32'h0000_0438, 4'b1111);
    rd(3'd4, d); check("R2 height readback", d, 32'h438);
    check("R2 readback not shadow", 32'(out_height), 0);
    wr(3'd0, 32'h0, 4'b1111);
  endtask

  task automatic t_latency();
    @(negedge clk); host_addr = 3'd4; host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
    check("R3 data after one cycle", host_rdata, 32'h438);
    @(negedge clk);
    check("R3 zero when idle", host_rdata, 0);
  endtask

  task automatic t_shadow();
    wr(3'd3, 32'd100, 4'b1111);
    wr(3'd4, 32'd50, 4'b1111);
    wr(3'd0, 32'h7, 4'b1111);
    check("R4 no effect before frame", 32'(out_width), 0);
    pulse_frame();
    check("R4 width captured", 32'(out_width), 100);
    check("R4 height captured", 32'(out_height), 50);
    check("R4 run captured", 32'(run), 1);
    check("R4 coef captured", 32'(edge_coef_en), 1);
    check("R4 sharp captured", 32'(edge_sharp_en), 1);
    wr(3'd3, 32'd200, 4'b1111);
    check("R4 mid-frame write held", 32'(out_width), 100);
    wr(3'd4, 32'd77, 4'b1111, 1'b1);
    check("R4 same-cycle write not captured", 32'(out_height), 50);
    check("R4 width from same capture", 32'(out_width), 200);
    pulse_frame();
    check("R4 later capture", 32'(out_height), 77);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    wr(3'd0, 32'h0, 4'b1111);
    check("R5 run held after clear", 32'(run), 1);
    rd(3'd1, d); check("R6 status busy", d, 1);
    pulse_frame();
    check("R5 run dropped at capture", 32'(run), 0);
    check("R5 coef dropped", 32'(edge_coef_en), 0);
    rd(3'd1, d); check("R6 status stopped", d, 0);
    wr(3'd1, 32'hFFFF_FFFF, 4'b1111);
    rd(3'd1, d); check("R6 status not writable", d, 0);
  endtask

  task automatic t_intr();
    logic [31:0] d;
    wr(3'd2, 32'hFFFF_FFFF, 4'b1111);
    rd(3'd2, d); check("R7 reads zero", d, 0);
    rd(3'd0, d); check("R7 ctrl untouched", d, 0);
    rd(3'd3, d); check("R7 width untouched", d, 200);
  endtask

  task automatic t_thresh();
    wr(3'd5, 32'd1000, 4'b1111);
    pulse_frame();
    check("R8 scaled", 32'(edge_thresh), 3000);
    wr(3'd5, 32'h0000_FFFF, 4'b1111);
    pulse_frame();
    check("R8 max scaled", 32'(edge_thresh), 32'd196605);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(3'd6, 32'hFFFF_FFFF, 4'b1111);
    wr(3'd7, 32'hFFFF_FFFF, 4'b1111);
    rd(3'd6, d); check("R9 addr6 zero", d, 0);
    rd(3'd7, d); check("R9 addr7 zero", d, 0);
    rd(3'd4, d); check("R9 height untouched", d, 77);
    pulse_frame();
    check("R9 run untouched", 32'(run), 0);
    check("R9 width output untouched", 32'(out_width), 200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lanes();
    t_map();
    t_latency();
    t_shadow();
    t_stop();
    t_intr();
    t_thresh();
    t_unmapped();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule